// File: doc/BRIEF.md
# Clear-on-Read Split Error Counter

This block accumulates single-cycle error pulses from a pattern verifier into a wide counter and presents the count to software through two half-width registers on a simple read bus. The counter is twice as wide as the read data path, so one value takes two reads. Reading the upper half returns the top bits, copies the bottom bits of the same count into a holding register, and clears the live counter. A read of the lower half that follows returns that held copy, so the two reads together give one coherent value.

Errors keep counting while software reads. A pulse that lands in the same cycle as the clearing read is kept as the first count of the new interval. The counter stops at all ones rather than wrapping. When the verifier is switched off, the live count and the held lower half are both forced to zero. Read data is registered and appears one cycle after the request, together with a valid strobe.

Top module: `split_err_counter`

## Requirements
- R1: After reset the live count and the held lower half are zero, and `rd_valid` is 0 with `rd_data` 0 until a read is requested.
- R2: While `verify_en` is 1, each cycle with `err_pulse` at 1 and no upper-half read adds exactly one to the live count.
- R3: Once the count reaches all ones (0xFFFFFFFF at the default width), further pulses leave it at all ones. An upper read then returns all ones, and the lower read after it also returns all ones.
- R4: A request with `rd_en` at 1 and `rd_addr` equal to 0 (upper half) gives `rd_valid` at 1 one cycle later. `rd_data` then carries bits [31:16] of the count as it stood in the request cycle.
- R5: An upper read copies bits [15:0] of that same count into the held register. A later request at `rd_addr` equal to 1 (lower half) returns that copy one cycle after the request, with `rd_valid` at 1.
- R6: An upper read sets the live count to 0, or to 1 when `err_pulse` is 1 in the same cycle. Pulses that arrive between the upper read and the lower read count toward the next value.
- R7: A lower read leaves the live count unchanged and does not refresh the held copy. Lower reads that are not preceded by an upper read, repeated or not, return the stale held value.
- R8: While `verify_en` is 0, the live count and the held copy are forced to zero and pulses are ignored. After re-enabling, an upper read followed by a lower read returns 0 and 0.
- R9: A request at any address other than 0 or 1 gives `rd_valid` at 0 and `rd_data` at 0 in the next cycle, and it changes neither the count nor the held copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| verify_en | input | 1 | Verifier enable; when low, the count and the held copy are cleared |
| err_pulse | input | 1 | One error per cycle while high |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | 4 | Read address: 0 for the upper half, 1 for the lower half |
| rd_data | output | 16 | Registered read data, one cycle after the request |
| rd_valid | output | 1 | High for one cycle when `rd_data` answers a read at address 0 or 1 |

## Verification
A long run of back-to-back pulses pushes the count past the half boundary, so the upper and lower halves each hold a distinct non-zero part. This separates a correct split from swapped or truncated halves. Directed sequences then cover several cases:
- a pulse in the same cycle as the clearing read, which shows whether the pulse is lost or counted twice;
- repeated lower reads with no upper read before them, which separate a stale held value from a live one;
- pulses while disabled, and reads at unused addresses.

A second, narrow instance is driven into saturation to tell saturating from wrapping. A constrained-random mix of enable, pulse and read traffic is checked against a reference model every cycle.

// File: rtl/err_cnt_pkg.sv
// Package: shared types for the split error counter.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package err_cnt_pkg;

    // Update applied to the live count in one cycle
    typedef enum logic [1:0] {
        ACC_HOLD      = 2'd0,
        ACC_INC       = 2'd1,
        ACC_ZERO      = 2'd2,
        ACC_RESTART   = 2'd3
    } acc_op_e;

    // Decoded read request
    typedef struct packed {
        logic upper;
        logic lower;
    } rd_hit_t;

endpackage

// File: rtl/err_rd_decode.sv
// Module: err_rd_decode
// Turns a read strobe and address into upper/lower hit flags.
// Assumes ADDR_HI != ADDR_LO, so at most one hit is ever set.
module err_rd_decode
    import err_cnt_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int ADDR_HI = 0,
    parameter int ADDR_LO = 1
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output rd_hit_t           hit
);

    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(ADDR_HI);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(ADDR_LO);

    // Compare the address against the two register slots
    always_comb begin
        hit.upper = rd_en && (rd_addr == HI_A);
        hit.lower = rd_en && (rd_addr == LO_A);
    end

endmodule

// File: rtl/err_accum.sv
// Module: err_accum
// Live error count: increments on pulses, clears on an upper read, and is
// forced to zero while disabled. A pulse in the clearing cycle restarts the
// count at one. SATURATE selects stopping at all ones (1) or wrapping (0).
// Assumes err_pulse is at most one error per cycle.
module err_accum
    import err_cnt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter bit SATURATE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             verify_en,
    input  logic             err_pulse,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    acc_op_e          op;
    logic [CNT_W-1:0] inc_val;
    logic [CNT_W-1:0] cnt_nxt;

    // Pick the update for this cycle; disable outranks clear, and clear outranks increment
    always_comb begin
        if (!verify_en)      op = ACC_ZERO;
        else if (clear)      op = err_pulse ? ACC_RESTART : ACC_ZERO;
        else if (err_pulse)  op = ACC_INC;
        else                 op = ACC_HOLD;
    end

    generate
        if (SATURATE) begin : g_sat
            // Stop at all ones
            always_comb inc_val = (&cnt) ? cnt : cnt + ONE;
        end else begin : g_wrap
            // Roll over to zero
            always_comb inc_val = cnt + ONE;
        end
    endgenerate

    // Next-count selection
    always_comb begin
        case (op)
            ACC_INC:     cnt_nxt = inc_val;
            ACC_ZERO:    cnt_nxt = '0;
            ACC_RESTART: cnt_nxt = ONE;
            default:     cnt_nxt = cnt;
        endcase
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

endmodule

// File: rtl/err_snap_latch.sv
// Module: err_snap_latch
// Holds the lower half of the count captured at an upper read.
// Assumes capture is the upper-read hit; cleared while disabled.
module err_snap_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         verify_en,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture on an upper read, zero when disabled, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= '0;
        else if (!verify_en) q <= '0;
        else if (capture)    q <= d;
    end

endmodule

// File: rtl/err_rd_port.sv
// Module: err_rd_port
// Registers the read response: data and valid appear one cycle after a hit.
// Assumes at most one of the two hits is set in a cycle.
module err_rd_port
    import err_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  rd_hit_t      hit,
    input  logic [W-1:0] hi_val,
    input  logic [W-1:0] lo_val,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);

    logic [W-1:0] sel;

    // Choose the half named by the hit; zero when there is no hit
    always_comb begin
        if (hit.upper)      sel = hi_val;
        else if (hit.lower) sel = lo_val;
        else                sel = '0;
    end

    // Response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_data  <= sel;
            rd_valid <= hit.upper | hit.lower;
        end
    end

endmodule

// File: rtl/split_err_counter.sv
// Module: split_err_counter
// Top: wide error counter read as two halves. An upper read returns the top
// half, snapshots the bottom half and clears the count; a lower read returns
// the snapshot. Assumes CNT_W is even; a half is CNT_W/2 bits.
module split_err_counter
    import err_cnt_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 4,
    parameter int ADDR_HI  = 0,
    parameter int ADDR_LO  = 1,
    parameter bit SATURATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              verify_en,
    input  logic              err_pulse,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W/2-1:0] rd_data,
    output logic              rd_valid
);

    localparam int HALF_W = CNT_W / 2;

    rd_hit_t           hit;
    logic              hit_hi;
    logic              hit_lo;
    logic [CNT_W-1:0]  live_cnt;
    logic [HALF_W-1:0] lo_hold;

    // Flatten the hit struct for the checker
    always_comb begin
        hit_hi = hit.upper;
        hit_lo = hit.lower;
    end

    err_rd_decode #(
        .ADDR_W (ADDR_W),
        .ADDR_HI(ADDR_HI),
        .ADDR_LO(ADDR_LO)
    ) u_dec (
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .hit    (hit)
    );

    err_accum #(
        .CNT_W   (CNT_W),
        .SATURATE(SATURATE)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .verify_en(verify_en),
        .err_pulse(err_pulse),
        .clear    (hit.upper),
        .cnt      (live_cnt)
    );

    err_snap_latch #(
        .W(HALF_W)
    ) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .verify_en(verify_en),
        .capture  (hit.upper),
        .d        (live_cnt[HALF_W-1:0]),
        .q        (lo_hold)
    );

    err_rd_port #(
        .W(HALF_W)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .hi_val  (live_cnt[CNT_W-1:HALF_W]),
        .lo_val  (lo_hold),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

endmodule

// File: rtl/err_cnt_checker.sv
// Module: err_cnt_checker
// Temporal checks on the split error counter, bound into every instance.
// Assumes the default saturating variant.
module err_cnt_checker #(
    parameter int CNT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               verify_en,
    input logic               err_pulse,
    input logic               rd_hi,
    input logic               rd_lo,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W/2-1:0] lo_q,
    input logic [CNT_W/2-1:0] rd_data,
    input logic               rd_valid
);

    localparam int HALF_W = CNT_W / 2;
    localparam logic [CNT_W-1:0] MAXV = '1;

    assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_en && err_pulse && !rd_hi && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1);

    assert_sat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_en && !rd_hi && cnt == MAXV) |=> cnt == MAXV);

    assert_hi_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (rd_valid && rd_data == $past(cnt[CNT_W-1:HALF_W])));

    assert_lo_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (rd_valid && rd_data == $past(lo_q)));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_en && rd_hi) |=> cnt == CNT_W'($past(err_pulse)));

    assert_lo_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_en && rd_lo && !err_pulse) |=> ($stable(cnt) && $stable(lo_q)));

    assert_disabled_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !verify_en |=> (cnt == '0 && lo_q == '0));

    assert_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hi || rd_lo) |=> (!rd_valid && rd_data == '0));

endmodule

bind split_err_counter err_cnt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .verify_en(verify_en),
    .err_pulse(err_pulse),
    .rd_hi    (hit_hi),
    .rd_lo    (hit_lo),
    .cnt      (live_cnt),
    .lo_q     (lo_hold),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/tb_split_err_counter.sv
`timescale 1ns/1ps
// Bench: drives a default-width instance and a narrow one with the same stimulus,
// and checks both against a reference model each cycle.
module tb_split_err_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       verify_en = 1'b0;
    logic       err_pulse = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [3:0]  s_rd_data;
    logic        s_rd_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state: index 0 is the wide instance, 1 the narrow one
    longint unsigned m_cnt [2];
    longint unsigned m_lo  [2];
    int              m_w   [2] = '{32, 8};

    always #2.5 clk = ~clk;

    split_err_counter dut (
        .clk(clk), .rst_n(rst_n), .verify_en(verify_en), .err_pulse(err_pulse),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    split_err_counter #(.CNT_W(8)) dut_small (
        .clk(clk), .rst_n(rst_n), .verify_en(verify_en), .err_pulse(err_pulse),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(s_rd_data), .rd_valid(s_rd_valid)
    );

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint unsigned mask_of(input int w);
        return (longint'(1) << w) - 1;
    endfunction

    // One cycle: drive at the falling edge, update the model at the rising edge, check at the next falling edge
    task automatic step(input logic en, input logic err, input logic rd, input logic [3:0] addr, input string tag);
        longint unsigned ev [2];
        logic            evv;
        logic            hi;
        logic            lo;
        verify_en = en; err_pulse = err; rd_en = rd; rd_addr = addr;
        hi = rd && addr == 4'd0;
        lo = rd && addr == 4'd1;
        @(posedge clk);
        evv = hi || lo;
        for (int k = 0; k < 2; k++) begin
            int h = m_w[k] / 2;
            ev[k] = hi ? (m_cnt[k] >> h) : (lo ? m_lo[k] : 0);
            if (!en) begin
                m_cnt[k] = 0; m_lo[k] = 0;
            end else if (hi) begin
                m_lo[k]  = m_cnt[k] & mask_of(h);
                m_cnt[k] = err ? 1 : 0;
            end else if (err && m_cnt[k] != mask_of(m_w[k])) begin
                m_cnt[k] = m_cnt[k] + 1;
            end
        end
        @(negedge clk);
        chk({tag, " valid"}, rd_valid, evv);
        chk({tag, " data"}, rd_data, ev[0]);
        chk({tag, " valid small"}, s_rd_valid, evv);
        chk({tag, " data small"}, s_rd_data, ev[1]);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_cnt = '{0, 0}; m_lo = '{0, 0};
        verify_en = 1'b1; err_pulse = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs quiet in and after reset
        chk("R1 reset valid", rd_valid, 0);
        chk("R1 reset data", rd_data, 0);
        rst_n = 1'b1;
        step(1, 0, 0, 0, "R1 idle");
        step(1, 0, 1, 0, "R1 upper zero");
        step(1, 0, 1, 1, "R1 lower zero");

        // R2/R4/R5: count past the half boundary, then split read
        for (int i = 0; i < 70000; i++) step(1, 1, 0, 0, "R2 accumulate");
        step(1, 0, 1, 0, "R4 upper 0x0001");
        chk("R4 upper value", rd_data, 16'h0001);
        step(1, 0, 1, 1, "R5 lower 0x1170");
        chk("R5 lower value", rd_data, 16'h1170);

        // R6: pulse in the clearing cycle, plus pulses between the two reads
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R2 small run");
        step(1, 1, 1, 0, "R6 clear with pulse");
        step(1, 1, 1, 1, "R6 lower after clear");
        chk("R6 lower value", rd_data, 3);
        step(1, 0, 1, 0, "R6 upper restart");
        step(1, 0, 1, 1, "R6 lower restart");
        chk("R6 pulse kept", rd_data, 2);

        // R7: lower reads without an upper read return the stale copy and leave the count alone
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, "R2 run");
        step(1, 0, 1, 1, "R7 stale lower");
        chk("R7 stale value", rd_data, 2);
        step(1, 1, 1, 1, "R7 stale again");
        step(1, 0, 1, 0, "R7 upper");
        step(1, 0, 1, 1, "R7 lower fresh");
        chk("R7 count kept", rd_data, 6);

        // R8: disabled clears and ignores pulses
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R2 pre-disable");
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R8 disabled");
        step(1, 0, 1, 1, "R8 held copy cleared");
        chk("R8 held value", rd_data, 0);
        step(1, 0, 1, 0, "R8 upper");
        step(1, 0, 1, 1, "R8 lower");
        chk("R8 count value", rd_data, 0);

        // R9: unused addresses
        step(1, 1, 0, 0, "R2 one");
        step(1, 1, 1, 2, "R9 addr 2");
        step(1, 0, 1, 15, "R9 addr 15");
        step(1, 0, 1, 0, "R9 upper");
        step(1, 0, 1, 1, "R9 lower");
        chk("R9 count value", rd_data, 2);

        // R3: saturate the narrow instance
        for (int i = 0; i < 300; i++) step(1, 1, 0, 0, "R3 saturate");
        step(1, 1, 1, 0, "R3 upper");
        chk("R3 upper all ones", s_rd_data, 4'hF);
        step(1, 0, 1, 1, "R3 lower");
        chk("R3 lower all ones", s_rd_data, 4'hF);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic en  = ($urandom % 32) != 0;
            logic err = $urandom % 2;
            logic rd  = ($urandom % 6) == 0;
            logic [3:0] a = 4'($urandom % 4);
            step(en, err, rd, a, "R2/R4/R5/R6/R7/R8/R9 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule